// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block is the source-side controller that walks a display output through its self-refresh states. Software gives it three control bits: a master enable, a request to enter active self-refresh, and a one-shot request for a single-frame update. A per-frame vertical-blank tick and an acknowledge from the sink-wake logic complete its inputs. From these it drives a numbered state code, a flag that marks a state change still in progress, a flag that marks self-refresh as active, and a one-cycle pulse that asks the link side to wake the panel.

Some transitions come from software. Others the block makes by itself: it counts idle frames before it commits to a static image, returns to the active state after one updated frame, and goes back to inactive once the sink has been woken. A watchdog raises a sticky error flag when a state change does not finish in time.

Top module: `srf_sequencer`

## Requirements
- R1: The state code on `state_o` is 0 disabled, 1 inactive, 2 entering active, 3 active with no remote-buffer update, 4 active with single-frame update, 5 exit. After reset the state is 0 and `in_trans_o`, `sr_active_o`, `wake_req_o`, `sfu_pending_o` and `timeout_err_o` are all 0.
- R2: With `enable_i` high, state 0 moves to state 1 and stays there while `entry_i` is low. Enabling never starts self-refresh by itself.
- R3: `entry_i` high in state 1 moves the machine to state 2. It moves on to state 3 on the vblank tick that makes the count of ticks seen in state 2 equal to max(6, IDLE_FRAMES). Cycles without a tick do not count.
- R4: In state 3, a low `entry_i` (or a low `enable_i`) moves the machine straight to state 5 and never through state 4.
- R5: `wake_req_o` is high for exactly the first cycle of every stay in state 5. State 5 holds until `wake_ack_i` is high, and the machine then moves to state 1.
- R6: A high `sfu_req_i` outside state 0 sets `sfu_pending_o` at the next edge. In state 3 a set pending flag moves the machine to state 4. In state 4 the next vblank tick returns it to state 3 and clears `sfu_pending_o` at the same edge.
- R7: `in_trans_o` is high exactly while the state is 2, 4 or 5.
- R8: `sr_active_o` is high exactly while the state is 3 or 4.
- R9: With `enable_i` low, state 1 goes to state 0. A transition in progress (state 2 or 4) first runs to state 3, which then exits through state 5 and state 1 to state 0.
- R10: When `in_trans_o` stays high for TIMEOUT_CYCLES consecutive cycles, `timeout_err_o` goes high and stays high until reset.
- R11: In state 0, `entry_i` and `sfu_req_i` have no effect: the state stays 0 and `sfu_pending_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Master enable for self-refresh control |
| entry_i | input | 1 | Level request to enter active self-refresh |
| sfu_req_i | input | 1 | One-cycle request for a single-frame update |
| vblank_i | input | 1 | One-cycle tick once per frame |
| wake_ack_i | input | 1 | Sink wake has been sent and acknowledged |
| state_o | output | 3 | Current state code |
| in_trans_o | output | 1 | A state change is in progress |
| sr_active_o | output | 1 | Self-refresh is active |
| wake_req_o | output | 1 | Single-cycle request to wake the sink |
| sfu_pending_o | output | 1 | A single-frame update is requested and not yet done |
| timeout_err_o | output | 1 | Sticky error: a transition took too long |

## Verification
Every output is a register loaded from the inputs seen at one rising edge. A change in the control inputs therefore shows on `state_o`, the flags and the wake pulse one edge later. `sfu_pending_o` is set at that same edge, and the move from state 3 to state 4 that it causes comes one edge after that. The bench changes inputs on the falling edge and checks on the next falling edge, so each check lands exactly one edge after its stimulus. The idle-frame boundary is swept tick by tick with a parameter below the minimum of six. The timeout is checked on both sides of its cycle limit.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_ENTER   = 3'd2,
    ST_STATIC  = 3'd3,
    ST_SFU     = 3'd4,
    ST_EXIT    = 3'd5
  } srf_state_e;

  localparam int unsigned MIN_IDLE_FRAMES = 6;

  function automatic logic is_transient(input srf_state_e s);
    return (s == ST_ENTER) || (s == ST_SFU) || (s == ST_EXIT);
  endfunction

  function automatic logic is_live(input srf_state_e s);
    return (s == ST_STATIC) || (s == ST_SFU);
  endfunction

endpackage

// File: rtl/srf_frame_counter.sv
module srf_frame_counter #(
  parameter int unsigned LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (tick_i && (cnt_q != CW'(LIMIT))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // High when the next tick completes the idle window
  assign last_o = (cnt_q == CW'(LIMIT - 1));

  p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/srf_sfu_latch.sv
module srf_sfu_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic done_i,
  input  logic flush_i,
  output logic pending_o
);
  always_ff @(posedge clk) begin
    if (rst || flush_i || done_i) begin
      pending_o <= 1'b0;
    end else if (set_i) begin
      pending_o <= 1'b1;
    end
  end

  p_done_clears_r6: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !pending_o);

endmodule

// File: rtl/srf_trans_timer.sv
module srf_trans_timer #(
  parameter int unsigned LIMIT = 1 << 20
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  output logic err_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !busy_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o <= 1'b0;
    end else if (busy_i && (cnt_q == CW'(LIMIT - 1))) begin
      err_o <= 1'b1;
    end
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

endmodule

// File: rtl/srf_sequencer.sv
module srf_sequencer
  import srf_pkg::*;
#(
  parameter int unsigned IDLE_FRAMES    = 6,
  parameter int unsigned TIMEOUT_CYCLES = 1 << 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable_i,
  input  logic       entry_i,
  input  logic       sfu_req_i,
  input  logic       vblank_i,
  input  logic       wake_ack_i,
  output logic [2:0] state_o,
  output logic       in_trans_o,
  output logic       sr_active_o,
  output logic       wake_req_o,
  output logic       sfu_pending_o,
  output logic       timeout_err_o
);
  // Idle window never shorter than the minimum the sink needs
  localparam int unsigned IDLE_EFF =
    (IDLE_FRAMES < MIN_IDLE_FRAMES) ? MIN_IDLE_FRAMES : IDLE_FRAMES;

  srf_state_e state_q, state_d;
  logic       idle_last;
  logic       sfu_done;

  srf_frame_counter #(.LIMIT(IDLE_EFF)) u_idle_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (state_q != ST_ENTER),
    .tick_i  (vblank_i),
    .last_o  (idle_last)
  );

  assign sfu_done = (state_q == ST_SFU) && vblank_i;

  srf_sfu_latch u_sfu (
    .clk       (clk),
    .rst       (rst),
    .set_i     (sfu_req_i && (state_q != ST_OFF)),
    .done_i    (sfu_done),
    .flush_i   (state_q == ST_OFF),
    .pending_o (sfu_pending_o)
  );

  srf_trans_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .busy_i (in_trans_o),
    .err_o  (timeout_err_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (enable_i) state_d = ST_IDLE;
      ST_IDLE: begin
        if (!enable_i)    state_d = ST_OFF;
        else if (entry_i) state_d = ST_ENTER;
      end
      ST_ENTER:  if (vblank_i && idle_last) state_d = ST_STATIC;
      ST_STATIC: begin
        if (!enable_i || !entry_i) state_d = ST_EXIT;
        else if (sfu_pending_o)    state_d = ST_SFU;
      end
      ST_SFU:    if (vblank_i) state_d = ST_STATIC;
      ST_EXIT:   if (wake_ack_i) state_d = ST_IDLE;
      default:   state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_OFF;
      in_trans_o  <= 1'b0;
      sr_active_o <= 1'b0;
      wake_req_o  <= 1'b0;
    end else begin
      state_q     <= state_d;
      in_trans_o  <= is_transient(state_d);
      sr_active_o <= is_live(state_d);
      wake_req_o  <= (state_d == ST_EXIT) && (state_q != ST_EXIT);
    end
  end

  assign state_o = state_q;

  p_legal_code_r1: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd5);

  p_enable_only_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF) |=> (state_q == ST_OFF || state_q == ST_IDLE));

  p_enter_to_static_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENTER) |=> (state_q == ST_ENTER || state_q == ST_STATIC));

  p_exit_skips_sfu_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_STATIC && !entry_i) |=> (state_q == ST_EXIT));

  p_wake_on_entry_r5: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> (state_q == ST_EXIT && $past(state_q) != ST_EXIT));

  p_exit_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXIT && !wake_ack_i) |=> (state_q == ST_EXIT));

  p_trans_flag_r7: assert property (@(posedge clk) disable iff (rst)
    in_trans_o |-> (state_o == 3'd2 || state_o == 3'd4 || state_o == 3'd5));

  p_active_flag_r8: assert property (@(posedge clk) disable iff (rst)
    sr_active_o |-> (state_o == 3'd3 || state_o == 3'd4));

  p_off_ignores_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFF && !enable_i) |=> (state_q == ST_OFF && !sfu_pending_o));

endmodule

// File: tb/srf_sequencer_bench.sv
module srf_sequencer_bench;
  logic clk = 1'b0;
  logic rst;
  logic enable_i, entry_i, sfu_req_i, vblank_i, wake_ack_i;
  logic [2:0] state_o;
  logic in_trans_o, sr_active_o, wake_req_o, sfu_pending_o, timeout_err_o;

  int n_run  = 0;
  int n_fail = 0;

  localparam int TMO = 200;

  always #2.5 clk = ~clk;

  srf_sequencer #(.IDLE_FRAMES(2), .TIMEOUT_CYCLES(TMO)) u_srf_sequencer (
    .clk(clk), .rst(rst), .enable_i(enable_i), .entry_i(entry_i),
    .sfu_req_i(sfu_req_i), .vblank_i(vblank_i), .wake_ack_i(wake_ack_i),
    .state_o(state_o), .in_trans_o(in_trans_o), .sr_active_o(sr_active_o),
    .wake_req_o(wake_req_o), .sfu_pending_o(sfu_pending_o),
    .timeout_err_o(timeout_err_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // Flags are due from the state code alone (R7, R8)
  task automatic chk_flags(input int s);
    chk("R7", in_trans_o, (s == 2 || s == 4 || s == 5) ? 1 : 0);
    chk("R8", sr_active_o, (s == 3 || s == 4) ? 1 : 0);
  endtask

  task automatic vbl();
    vblank_i = 1'b1; tick(); vblank_i = 1'b0;
  endtask

  task automatic go_static();
    entry_i = 1'b1; tick();
    for (int k = 0; k < 6; k++) vbl();
  endtask

  task automatic exit_and_ack();
    entry_i = 1'b0; tick();
    wake_ack_i = 1'b1; tick(); wake_ack_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; enable_i = 0; entry_i = 0; sfu_req_i = 0; vblank_i = 0; wake_ack_i = 0;
    repeat (3) tick();
    rst = 1'b0; tick();
    // R1 reset state
    chk("R1", state_o, 0); chk("R1", in_trans_o, 0); chk("R1", wake_req_o, 0);
    chk("R1", sfu_pending_o, 0); chk("R1", timeout_err_o, 0); chk("R1", sr_active_o, 0);

    // R11: entry and sfu ignored while disabled
    entry_i = 1; sfu_req_i = 1; tick(); sfu_req_i = 0; tick();
    chk("R11", state_o, 0); chk("R11", sfu_pending_o, 0);
    entry_i = 0;

    // R2 enable only reaches inactive
    enable_i = 1; tick();
    chk("R2", state_o, 1); chk_flags(1);
    repeat (5) vbl();
    chk("R2", state_o, 1);

    // R3 sweep of the idle window; parameter 2 is raised to 6
    entry_i = 1; tick();
    chk("R3", state_o, 2); chk_flags(2);
    for (int k = 1; k <= 6; k++) begin
      tick(); tick();
      chk("R3 no-tick", state_o, 2);
      vbl();
      chk("R3", state_o, (k < 6) ? 2 : 3);
    end
    chk_flags(3);

    // R4/R5 exit straight from 3 to 5, wake pulse one cycle
    entry_i = 0; tick();
    chk("R4", state_o, 5); chk("R5", wake_req_o, 1); chk_flags(5);
    tick();
    chk("R5", wake_req_o, 0); chk("R5", state_o, 5);
    repeat (4) tick();
    chk("R5", state_o, 5);
    wake_ack_i = 1; tick(); wake_ack_i = 0;
    chk("R5", state_o, 1); chk("R5", wake_req_o, 0);

    // R6 single-frame update
    go_static();
    chk("R6", state_o, 3);
    sfu_req_i = 1; tick(); sfu_req_i = 0;
    chk("R6", sfu_pending_o, 1); chk("R6", state_o, 3);
    tick();
    chk("R6", state_o, 4); chk_flags(4);
    tick(); tick();
    chk("R6", state_o, 4); chk("R6", sfu_pending_o, 1);
    vbl();
    chk("R6", state_o, 3); chk("R6", sfu_pending_o, 0);
    tick();
    chk("R6", state_o, 3);
    exit_and_ack();
    chk("R5", state_o, 1);

    // R6 request latched in inactive, taken after entry
    sfu_req_i = 1; tick(); sfu_req_i = 0;
    chk("R6", sfu_pending_o, 1);
    go_static();
    chk("R6", state_o, 3);
    tick();
    chk("R6", state_o, 4);
    vbl();
    chk("R6", sfu_pending_o, 0);
    exit_and_ack();

    // R9 disable in inactive
    enable_i = 0; tick();
    chk("R9", state_o, 0);
    enable_i = 1; tick();
    chk("R9", state_o, 1);

    // R9 disable during entry waits for completion, then exits
    entry_i = 1; tick();
    enable_i = 0;
    repeat (3) tick();
    chk("R9", state_o, 2);
    for (int k = 0; k < 5; k++) vbl();
    chk("R9", state_o, 2);
    vbl();
    chk("R9", state_o, 3);
    tick();
    chk("R9", state_o, 5); chk("R9", wake_req_o, 1);
    wake_ack_i = 1; tick(); wake_ack_i = 0;
    chk("R9", state_o, 1);
    tick();
    chk("R9", state_o, 0);
    entry_i = 0;

    // R9 disable during single-frame update
    enable_i = 1; tick();
    go_static();
    sfu_req_i = 1; tick(); sfu_req_i = 0;
    tick();
    chk("R9", state_o, 4);
    enable_i = 0; tick();
    chk("R9", state_o, 4);
    vbl();
    chk("R9", state_o, 3);
    tick();
    chk("R9", state_o, 5);
    wake_ack_i = 1; tick(); wake_ack_i = 0; tick();
    chk("R9", state_o, 0);
    entry_i = 0;

    // R10 timeout on a wake that never comes
    chk("R10", timeout_err_o, 0);
    enable_i = 1; tick();
    go_static();
    entry_i = 0; tick();
    chk("R10", state_o, 5);
    repeat (TMO - 20) tick();
    chk("R10", timeout_err_o, 0);
    repeat (40) tick();
    chk("R10", timeout_err_o, 1);
    wake_ack_i = 1; tick(); wake_ack_i = 0;
    repeat (3) tick();
    chk("R10", state_o, 1); chk("R10", timeout_err_o, 1);
    rst = 1; tick(); rst = 0; tick();
    chk("R10", timeout_err_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule